// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This block is a host-side controller that takes a parallel flash device through a complete chip erase with no help from software. After a single `start` pulse it turns on the program voltage and lets it settle. It then programs every byte to 00H, checking each one, and only then starts issuing erase pulses. After each pulse it reads back byte by byte. When a byte reads as erased, it moves on to the next address without another pulse. When a byte is still not erased, it issues a new pulse and resumes at that same address, because every address below it has already passed.

All device traffic goes through a simple bus-cycle port. The block raises a request that carries a write/read flag, an address and write data, and holds it until the bus side returns a one-cycle `bus_done`, together with the read data for reads. Every delay the algorithm needs is counted in clock cycles, and each delay is a parameter: voltage settle, program time, erase pulse time and verify settle. The number of erase pulses and the number of program attempts per byte are both bounded by parameters. The run ends with a one-cycle `done` or `error`, and the program voltage is already removed in that cycle.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `busy`, `vpp_en`, `done`, `error` and `bus_req` are low. The block issues no bus request until `start` is seen while idle, and a `start` that arrives during a run has no effect on that run.
- R2: `vpp_en` rises in the cycle after `start`. The first bus request rises no sooner than RAMP_WAIT cycles after that, and `vpp_en` is high whenever `bus_req` is high.
- R3: Pre-programming visits addresses in ascending order from 0. For each address it issues these bus cycles in order:
  - write 40H to address 0;
  - write 00H to the address itself;
  - wait at least PROG_WAIT cycles, then write C0H to address 0;
  - wait at least VERIFY_WAIT cycles, then read the address.
- R4: A pre-program read other than 00H repeats the R3 sequence for the same address. A byte that fails PROG_TRIES such reads ends the run with `error`.
- R5: After the last byte reads 00H, an erase pulse is issued: two writes of 20H to address 0. Verification then starts at address 0 with the pulse count at zero.
- R6: After each erase pulse, verification resumes at the current address, waiting at least ERASE_WAIT cycles before the first verify command. A verify step writes A0H to the address under test, waits at least VERIFY_WAIT cycles, then reads that address.
- R7: A verify read of FFH advances to the next address with no new pulse. Any other value issues a new erase pulse, and verification resumes at the same address.
- R8: When MAX_PULSES erase pulses have failed verification, the run ends with `error`, and no further bus request is made.
- R9: After the last address reads FFH, the block writes 00H to address 0, then pulses `done` with `vpp_en` low.
- R10: On every error path, `vpp_en` is low in the cycle in which `error` is high.
- R11: `done` and `error` are one-cycle pulses and never high together. `busy` is high from the cycle after `start` until the result cycle, and low in the result cycle.
- R12: While `bus_req` is high and `bus_done` is low, `bus_we`, `bus_addr` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a chip erase (taken only while idle) |
| bus_req | output | 1 | Bus cycle requested |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | ADDR_W | Device address of the cycle |
| bus_wdata | output | 8 | Write data / command byte |
| bus_rdata | input | 8 | Read data, valid with bus_done |
| bus_done | input | 1 | One-cycle completion of the current request |
| vpp_en | output | 1 | Program/erase voltage enable |
| done | output | 1 | One-cycle pulse: erase completed |
| error | output | 1 | One-cycle pulse: program or erase failure |
| busy | output | 1 | Run in progress |

## Verification
Every request rises one cycle after the state that owns it is entered. Each timed wait then adds its parameter plus one cycle, counted from the cycle in which the previous `bus_done` was sampled. The bench therefore measures each gap at the falling edge, from the last completion or from the rise of `vpp_en`, and checks it against the lower bound that the requirement states. Results are due one cycle after the final completion. The monitor samples `done`/`error` at falling edges, checks the voltage and `busy` in that same sample, and checks in the following sample that the pulse has ended.

// File: rtl/flash_erase_pkg.sv
// Shared definitions for the chip-erase sequencer: controller states and
// the command bytes understood by the flash device.
package flash_erase_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_RAMP,
        ST_PP_SETUP,
        ST_PP_DATA,
        ST_PP_WAIT,
        ST_PP_VCMD,
        ST_PP_VWAIT,
        ST_PP_READ,
        ST_ER_SETUP,
        ST_ER_GO,
        ST_ER_WAIT,
        ST_EV_CMD,
        ST_EV_WAIT,
        ST_EV_READ,
        ST_RD_CMD,
        ST_FINISH,
        ST_FAIL
    } seq_state_t;

    localparam logic [7:0] CMD_READ     = 8'h00;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_PROG     = 8'h40;
    localparam logic [7:0] CMD_EVERIFY  = 8'hA0;
    localparam logic [7:0] CMD_PVERIFY  = 8'hC0;
    localparam logic [7:0] BYTE_ZERO    = 8'h00;
    localparam logic [7:0] BYTE_ERASED  = 8'hFF;

endpackage

// File: rtl/fe_timer.sv
// Down-counting delay timer.
// Loading sets the count. The count then falls by one each cycle and
// holds at zero, and `zero` reports that the delay has run out.
// Assumes the owner loads it in the same cycle it enters a timed state.
module fe_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    // Count register: load has priority over the decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/fe_bus_if.sv
// Request holder for the device bus-cycle port.
// A one-cycle `issue` captures the cycle's type, address and data and
// raises bus_req. The request is held unchanged until bus_done, and
// op_done marks the completing cycle. Assumes `issue` is never given
// while a request is outstanding.
module fe_bus_if #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              op_we,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic              bus_done,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              op_done
);

    // Request flag: set on issue, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_req <= 1'b0;
        else if (bus_req && bus_done)
            bus_req <= 1'b0;
        else if (issue)
            bus_req <= 1'b1;
    end

    // Request fields: captured only when a new cycle is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (issue && !bus_req) begin
            bus_we    <= op_we;
            bus_addr  <= op_addr;
            bus_wdata <= op_data;
        end
    end

    assign op_done = bus_req && bus_done;

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_we) &&
                                    $stable(bus_addr) && $stable(bus_wdata)));

    a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !bus_req);

endmodule

// File: rtl/flash_erase_seq.sv
// Chip-erase sequencer top.
// It runs voltage settle, then pre-program to 00H with verify and retry,
// then erase pulses with a byte-by-byte verify that keeps its place
// between pulses, then the return to read mode. Bus cycles go through
// fe_bus_if and every wait through fe_timer.
// Assumes the bus side answers each request with exactly one bus_done.
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int RAMP_WAIT   = 10,
    parameter int PROG_WAIT   = 1000,
    parameter int ERASE_WAIT  = 1000000,
    parameter int VERIFY_WAIT = 600,
    parameter int MAX_PULSES  = 1000,
    parameter int PROG_TRIES  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_done,
    output logic              vpp_en,
    output logic              done,
    output logic              error,
    output logic              busy
);

    localparam int W_A   = (RAMP_WAIT > PROG_WAIT) ? RAMP_WAIT : PROG_WAIT;
    localparam int W_B   = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT;
    localparam int W_MAX = (W_A > W_B) ? W_A : W_B;
    localparam int TW    = $clog2(W_MAX + 1);
    localparam int PCW   = $clog2(MAX_PULSES + 1);
    localparam int TRW   = $clog2(PROG_TRIES + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    seq_state_t         st_q, st_d;
    logic [ADDR_W-1:0]  addr_q, addr_d;
    logic [PCW-1:0]     pulse_q, pulse_d;
    logic [TRW-1:0]     tries_q, tries_d;
    logic               pend_q;
    logic               tmr_load, tmr_zero;
    logic [TW-1:0]      tmr_val;
    logic               is_bus, issue, op_done;
    logic               op_we;
    logic [ADDR_W-1:0]  op_addr;
    logic [7:0]         op_data;

    fe_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    fe_bus_if #(.ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .op_we     (op_we),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .bus_done  (bus_done),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .op_done   (op_done)
    );

    // Marks the states that own one bus cycle.
    always_comb begin
        case (st_q)
            ST_PP_SETUP, ST_PP_DATA, ST_PP_VCMD, ST_PP_READ,
            ST_ER_SETUP, ST_ER_GO, ST_EV_CMD, ST_EV_READ,
            ST_RD_CMD: is_bus = 1'b1;
            default:   is_bus = 1'b0;
        endcase
    end

    assign issue = is_bus && !pend_q;

    // Next-state, bus-cycle contents and timer loads of the algorithm.
    always_comb begin
        st_d     = st_q;
        addr_d   = addr_q;
        pulse_d  = pulse_q;
        tries_d  = tries_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        op_we    = 1'b1;
        op_addr  = '0;
        op_data  = CMD_READ;
        case (st_q)
            ST_IDLE: if (start) begin
                st_d     = ST_RAMP;
                tmr_load = 1'b1;
                tmr_val  = TW'(RAMP_WAIT);
                addr_d   = '0;
                pulse_d  = '0;
                tries_d  = '0;
            end
            ST_RAMP: if (tmr_zero) st_d = ST_PP_SETUP;
            ST_PP_SETUP: begin
                op_data = CMD_PROG;
                if (op_done) st_d = ST_PP_DATA;
            end
            ST_PP_DATA: begin
                op_addr = addr_q;
                op_data = BYTE_ZERO;
                if (op_done) begin
                    st_d     = ST_PP_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PROG_WAIT);
                end
            end
            ST_PP_WAIT: if (tmr_zero) st_d = ST_PP_VCMD;
            ST_PP_VCMD: begin
                op_data = CMD_PVERIFY;
                if (op_done) begin
                    st_d     = ST_PP_VWAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(VERIFY_WAIT);
                end
            end
            ST_PP_VWAIT: if (tmr_zero) st_d = ST_PP_READ;
            ST_PP_READ: begin
                op_we   = 1'b0;
                op_addr = addr_q;
                if (op_done) begin
                    if (bus_rdata == BYTE_ZERO) begin
                        tries_d = '0;
                        if (addr_q == LAST_ADDR) begin
                            addr_d  = '0;
                            pulse_d = '0;
                            st_d    = ST_ER_SETUP;
                        end else begin
                            addr_d = addr_q + 1'b1;
                            st_d   = ST_PP_SETUP;
                        end
                    end else if (tries_q == TRW'(PROG_TRIES - 1)) begin
                        st_d = ST_FAIL;
                    end else begin
                        tries_d = tries_q + 1'b1;
                        st_d    = ST_PP_SETUP;
                    end
                end
            end
            ST_ER_SETUP: begin
                op_data = CMD_ERASE;
                if (op_done) st_d = ST_ER_GO;
            end
            ST_ER_GO: begin
                op_data = CMD_ERASE;
                if (op_done) begin
                    st_d     = ST_ER_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(ERASE_WAIT);
                end
            end
            ST_ER_WAIT: if (tmr_zero) st_d = ST_EV_CMD;
            ST_EV_CMD: begin
                op_addr = addr_q;
                op_data = CMD_EVERIFY;
                if (op_done) begin
                    st_d     = ST_EV_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(VERIFY_WAIT);
                end
            end
            ST_EV_WAIT: if (tmr_zero) st_d = ST_EV_READ;
            ST_EV_READ: begin
                op_we   = 1'b0;
                op_addr = addr_q;
                if (op_done) begin
                    if (bus_rdata == BYTE_ERASED) begin
                        if (addr_q == LAST_ADDR) begin
                            st_d = ST_RD_CMD;
                        end else begin
                            addr_d = addr_q + 1'b1;
                            st_d   = ST_EV_CMD;
                        end
                    end else if (pulse_q == PCW'(MAX_PULSES - 1)) begin
                        st_d = ST_FAIL;
                    end else begin
                        pulse_d = pulse_q + 1'b1;
                        st_d    = ST_ER_SETUP;
                    end
                end
            end
            ST_RD_CMD: begin
                op_data = CMD_READ;
                if (op_done) st_d = ST_FINISH;
            end
            ST_FINISH: st_d = ST_IDLE;
            ST_FAIL:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Sequencer registers: state, address, pulse and retry counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            pulse_q <= '0;
            tries_q <= '0;
        end else begin
            st_q    <= st_d;
            addr_q  <= addr_d;
            pulse_q <= pulse_d;
            tries_q <= tries_d;
        end
    end

    // Outstanding-cycle flag: one bus cycle per bus-owning state visit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (op_done)
            pend_q <= 1'b0;
        else if (issue)
            pend_q <= 1'b1;
    end

    assign done   = (st_q == ST_FINISH);
    assign error  = (st_q == ST_FAIL);
    assign vpp_en = !(st_q == ST_IDLE || st_q == ST_FINISH || st_q == ST_FAIL);
    assign busy   = vpp_en;

    a_r2_vpp_with_bus: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> vpp_en);

    a_r1_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r9_done_vpp_off: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!vpp_en && !bus_req));

    a_r10_error_vpp_off: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!vpp_en && !bus_req));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, error}));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> !(done || error));

    a_r8_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q < PCW'(MAX_PULSES));

    a_r4_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q < TRW'(PROG_TRIES));

endmodule

// File: tb/flash_erase_seq_bench.sv
// Scoreboard bench: a generator builds the expected bus cycles from the
// requirements, a device model answers them, a monitor compares.
module flash_erase_seq_bench;

    localparam int AW = 3, N = 8, RAMP = 5, PW = 6, EW = 20, VW = 4;
    localparam int MAXP = 4, PT = 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic bus_req, bus_we, bus_done = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata = 8'h00;
    logic vpp_en, done, error, busy;

    always #5 clk = ~clk;

    flash_erase_seq #(
        .ADDR_W(AW), .RAMP_WAIT(RAMP), .PROG_WAIT(PW), .ERASE_WAIT(EW),
        .VERIFY_WAIT(VW), .MAX_PULSES(MAXP), .PROG_TRIES(PT)
    ) u_flash_erase_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_done(bus_done), .vpp_en(vpp_en),
        .done(done), .error(error), .busy(busy)
    );

    typedef struct {
        bit    we;
        int    addr;
        int    data;
        int    gap;
        bit    first;
        string tag;
    } op_t;

    op_t   exp_q[$];
    int    checks = 0, fails = 0, cyc = 0;
    int    pf[N], nd[N];
    bit    exp_err;
    string exp_tag;

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(bit we, int addr, int data, int gap, bit first, string tag);
        op_t o;
        o.we = we; o.addr = addr; o.data = data; o.gap = gap; o.first = first; o.tag = tag;
        exp_q.push_back(o);
    endtask

    // Driver side: expected cycle list from R3..R9 and the device behaviour.
    task automatic gen();
        int lpf[N];
        int tries, pulses, a;
        bit first = 1'b1;
        bit stop  = 1'b0;
        for (int i = 0; i < N; i++) lpf[i] = pf[i];
        exp_q.delete();
        for (int i = 0; i < N && !stop; i++) begin
            tries = 0;
            forever begin
                push(1, 0, 8'h40, first ? RAMP : 0, first, first ? "R2" : "R3");
                first = 1'b0;
                push(1, i, 8'h00, 0, 0, "R3");
                push(1, 0, 8'hC0, PW, 0, "R3");
                push(0, i, 0, VW, 0, "R3");
                if (lpf[i] > 0) begin
                    lpf[i]--;
                    tries++;
                    if (tries == PT) begin stop = 1'b1; break; end
                end else break;
            end
        end
        if (stop) begin exp_err = 1'b1; exp_tag = "R4"; return; end
        pulses = 0; a = 0;
        forever begin
            push(1, 0, 8'h20, 0, 0, "R5");
            push(1, 0, 8'h20, 0, 0, "R5");
            push(1, a, 8'hA0, EW, 0, "R6");
            push(0, a, 0, VW, 0, "R6");
            while (a < N && pulses + 1 >= nd[a]) begin
                a++;
                if (a < N) begin
                    push(1, a, 8'hA0, 0, 0, "R7");
                    push(0, a, 0, VW, 0, "R7");
                end
            end
            if (a == N) begin
                push(1, 0, 8'h00, 0, 0, "R9");
                exp_err = 1'b0; exp_tag = "R9"; return;
            end
            pulses++;
            if (pulses == MAXP) begin exp_err = 1'b1; exp_tag = "R8"; return; end
        end
    endtask

    // Device model: two-cycle latency, program/erase effects on a byte array.
    logic [7:0] mem[N];
    int  m_pf[N];
    int  applied, lat;
    bit  pend_prog, pend_er;
    always @(posedge clk) begin
        if (bus_req && !bus_done) begin
            if (lat == 1) begin
                bus_done <= 1'b1;
                lat = 0;
                if (bus_we) begin
                    if (pend_prog) begin
                        if (m_pf[bus_addr] > 0) m_pf[bus_addr]--;
                        else mem[bus_addr] = mem[bus_addr] & bus_wdata;
                        pend_prog = 1'b0;
                    end else if (bus_wdata == 8'h40) begin
                        pend_prog = 1'b1; pend_er = 1'b0;
                    end else if (bus_wdata == 8'h20) begin
                        if (pend_er) begin
                            applied++;
                            for (int i = 0; i < N; i++)
                                if (applied >= nd[i]) mem[i] = 8'hFF;
                            pend_er = 1'b0;
                        end else pend_er = 1'b1;
                    end else pend_er = 1'b0;
                end else begin
                    bus_rdata <= mem[bus_addr];
                end
            end else lat++;
        end else begin
            bus_done <= 1'b0;
            lat = 0;
        end
    end

    // Monitor: compares cycles, gaps, holds and results at falling edges.
    bit prev_req = 0, prev_vpp = 0, prev_res = 0, res_seen = 0;
    int vpp_cyc = 0, done_cyc = 0;
    op_t cur;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (vpp_en && !prev_vpp) vpp_cyc = cyc;
            if (bus_req && !prev_req) begin
                if (exp_q.size() == 0) begin
                    check(0, "R1", "unexpected bus request addr", int'(bus_addr), 0);
                end else begin
                    cur = exp_q.pop_front();
                    check(bus_we == cur.we, cur.tag, "cycle type", int'(bus_we), int'(cur.we));
                    check(int'(bus_addr) == cur.addr, cur.tag, "address", int'(bus_addr), cur.addr);
                    if (cur.we)
                        check(int'(bus_wdata) == cur.data, cur.tag, "write data",
                              int'(bus_wdata), cur.data);
                    check((cyc - (cur.first ? vpp_cyc : done_cyc)) >= cur.gap, cur.tag,
                          "gap cycles", cyc - (cur.first ? vpp_cyc : done_cyc), cur.gap);
                    check(vpp_en == 1'b1, "R2", "vpp during request", int'(vpp_en), 1);
                    check(busy == 1'b1, "R11", "busy during run", int'(busy), 1);
                end
            end else if (bus_req && prev_req) begin
                check(bus_we == cur.we && int'(bus_addr) == cur.addr &&
                      (!cur.we || int'(bus_wdata) == cur.data), "R12",
                      "request held addr", int'(bus_addr), cur.addr);
            end
            if (bus_done) done_cyc = cyc;
            if (prev_res)
                check(!done && !error, "R11", "result pulse length", int'(done | error), 0);
            if (done || error) begin
                res_seen = 1'b1;
                check(!(done && error), "R11", "done and error together", 1, 0);
                check(error == exp_err, exp_tag, "error flag", int'(error), int'(exp_err));
                check(exp_q.size() == 0, exp_tag, "cycles left", exp_q.size(), 0);
                check(!vpp_en, error ? "R10" : "R9", "vpp at result", int'(vpp_en), 0);
                check(!busy, "R11", "busy at result", int'(busy), 0);
            end
            prev_res = done || error;
        end
        prev_req = bus_req;
        prev_vpp = vpp_en;
    end

    task automatic run(bit extra_start);
        int n;
        for (int i = 0; i < N; i++) begin mem[i] = 8'h5A; m_pf[i] = pf[i]; end
        applied = 0; pend_prog = 0; pend_er = 0;
        gen();
        res_seen = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(vpp_en && busy, "R2", "vpp and busy after start", int'(vpp_en), 1);
        n = 0;
        while (!res_seen && cyc < 150000) begin
            @(negedge clk);
            n++;
            if (extra_start && n == 40) start = 1'b1;   // R1: ignored mid-run
            else start = 1'b0;
        end
        if (!res_seen) check(0, exp_tag, "watchdog expired", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin pf[i] = 0; nd[i] = 1; end
        exp_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !vpp_en && !done && !error && !bus_req, "R1", "reset outputs",
              int'({busy, vpp_en, done, error, bus_req}), 0);
        repeat (20) @(negedge clk);                    // R1: idle, no requests
        // R3/R5/R9: clean run
        run(1'b0);
        // R4/R6/R7: retries and place-keeping across pulses, stray start
        pf[1] = 2; nd[2] = 3; nd[4] = 2; nd[7] = 4;
        run(1'b1);
        // R8/R10: one byte never erases within the pulse limit
        for (int i = 0; i < N; i++) begin pf[i] = 0; nd[i] = 1; end
        nd[3] = MAXP + 1;
        run(1'b0);
        // R4/R10: one byte never programs
        nd[3] = 1; pf[6] = PT;
        run(1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule